// File: doc/BRIEF.md
# Flash Erase-Suspend Control Register

This block is an 8-bit control register that sits next to a flash erase sequencer. Software uses it to allow erase suspension and to request a suspend. An enabled interrupt can also raise the suspend request without software. Three of the bits are mode bits: suspend enable, interrupt-driven suspend enable and low-current read mode. A single write cannot set any of them. Each one becomes 1 only when a write of 1 follows a write that cleared the bit. Clearing the suspend request restarts the erase, and that clear is accepted only while CPU rewrite mode is active.

The write side is a valid/ready port. `bus_sel` marks a write as addressed to this register. A write with `bus_sel` low goes to some other address, and its only effect here is to cancel any unlock in progress. The register never applies back-pressure, so `bus_ready` is always 1. A transfer completes on every clock edge where `bus_valid` is high. The read value comes straight from the register state.

The low-current read-mode bit clears itself when the device wakes from wait or stop mode with a fast wake clock or with undivided clocking. This protects read timing after the clock speeds up.

Top module: `fsusp_ctl_reg`

## Requirements
- R1: After reset every bit of `rd_data` is 0, and `suspend_o`, `no_wait_cycle_o` and `low_cur_read_o` are 0.
- R2: Bit 6 always reads 0. Bits 3, 4 and 5 take the written value on every accepted write. `no_wait_cycle_o` follows bit 4.
- R3: Guarded bits 0 (suspend enable), 2 (interrupt suspend enable) and 7 (low-current read) behave as follows on an accepted write:
  - writing 0 clears the bit;
  - writing 1 sets the bit only if the previous accepted write to this register wrote 0 to that same bit;
  - otherwise the bit keeps its value.
- R4: An accepted write with `bus_sel` low cancels every pending unlock and changes no register bit.
- R5: Writing 1 to bit 1 (suspend request) sets it.
- R6: Writing 0 to bit 1 clears it only while `rewrite_en` is 1. Otherwise bit 1 keeps its value.
- R7: On a cycle where `irq_req` is 1, the following applies:
  - if bit 2 is 1, bit 1 reads 1 after the next clock edge;
  - if bit 2 is 0, the interrupt has no effect.
- R8: When an interrupt sets bit 1 and a software clear of bit 1 happen in the same cycle, bit 1 ends up 1.
- R9: When `wake_evt` is 1 and either `wake_clk_sel` is 2'b10 or 2'b11 or `wake_nodiv` is 1, bit 7 is cleared. This wins over a same-cycle write. Otherwise the wake event leaves bit 7 unchanged.
- R10: `suspend_o` is 1 exactly when bits 0 and 1 are both 1.
- R11: `bus_ready` is always 1. A write takes effect only when `bus_valid` is 1, and it appears on `rd_data` after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Write transfer valid |
| bus_ready | output | 1 | Write transfer ready (always 1) |
| bus_sel | input | 1 | Transfer addresses this register |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| irq_req | input | 1 | Enabled interrupt request strobe |
| rewrite_en | input | 1 | CPU rewrite mode active |
| wake_evt | input | 1 | Exit from wait or stop mode |
| wake_clk_sel | input | 2 | System clock choice on wake |
| wake_nodiv | input | 1 | Clock runs undivided on wake |
| suspend_o | output | 1 | Erase suspend in effect |
| no_wait_cycle_o | output | 1 | Flash wait-cycle control bit |
| low_cur_read_o | output | 1 | Low-current read mode active |

## Verification
The unlock logic is tried in four ways:
- a lone write of 1, to show that a single write cannot set a guarded bit;
- a proper 0-then-1 pair;
- a pair broken by a write elsewhere, to show that arming is tied to this register only;
- a repeat write of 1 to a bit that is already set, to show that it holds.

The suspend request is driven by software set, by restart with and without rewrite mode, and by an interrupt with the enable both clear and set, with one case where the interrupt collides with a restart. Bit 7 is woken under every clock-select value and the no-division input, and once with a same-cycle write, which separates the clearing cases from the holding ones and confirms the priority.

// File: rtl/fsusp_pkg.sv
package fsusp_pkg;
  localparam int REG_W      = 8;
  localparam int EN_BIT     = 0;
  localparam int REQ_BIT    = 1;
  localparam int IRQEN_BIT  = 2;
  localparam int WAIT_BIT   = 4;
  localparam int LCR_BIT    = 7;
  localparam int CSEL_W     = 2;
  localparam logic [REG_W-1:0] GUARD_MASK = 8'h85;
  localparam logic [REG_W-1:0] PLAIN_MASK = 8'h38;

  typedef struct packed {
    logic              evt;
    logic [CSEL_W-1:0] clk_sel;
    logic              nodiv;
  } wake_t;
endpackage

// File: rtl/fsusp_unlock_bit.sv
module fsusp_unlock_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_here,
  input  logic wr_other,
  input  logic wbit,
  input  logic force_clr,
  output logic q
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (force_clr)
        q <= 1'b0;
      else if (wr_here)
        q <= wbit ? (q | armed) : 1'b0;

      if (wr_here)
        armed <= ~wbit;
      else if (wr_other)
        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/fsusp_req_bit.sv
module fsusp_req_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_here,
  input  logic wbit,
  input  logic rewrite_en,
  input  logic irq_req,
  input  logic irq_en,
  output logic q
);
  logic hw_set;
  logic sw_set;
  logic sw_clr;

  always_comb begin
    hw_set = irq_req & irq_en;
    sw_set = wr_here & wbit;
    sw_clr = wr_here & ~wbit & rewrite_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else if (hw_set | sw_set)
      q <= 1'b1;
    else if (sw_clr)
      q <= 1'b0;
  end
endmodule

// File: rtl/fsusp_wake_clr.sv
module fsusp_wake_clr
  import fsusp_pkg::*;
#(
  parameter int SEL_W = CSEL_W
) (
  input  logic             wake_evt,
  input  logic [SEL_W-1:0] wake_clk_sel,
  input  logic             wake_nodiv,
  output logic             clr
);
  logic fast_clk;

  always_comb begin
    fast_clk = wake_clk_sel[SEL_W-1];
    clr      = wake_evt & (fast_clk | wake_nodiv);
  end
endmodule

// File: rtl/fsusp_ctl_reg.sv
module fsusp_ctl_reg
  import fsusp_pkg::*;
#(
  parameter int W = REG_W,
  parameter logic [REG_W-1:0] GMASK = GUARD_MASK,
  parameter logic [REG_W-1:0] PMASK = PLAIN_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_sel,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      rd_data,
  input  logic              irq_req,
  input  logic              rewrite_en,
  input  logic              wake_evt,
  input  logic [CSEL_W-1:0] wake_clk_sel,
  input  logic              wake_nodiv,
  output logic              suspend_o,
  output logic              no_wait_cycle_o,
  output logic              low_cur_read_o
);
  logic         fire;
  logic         wr_here;
  logic         wr_other;
  logic         lcr_clr;
  logic [W-1:0] reg_q;
  wake_t        wk;

  always_comb begin
    bus_ready = 1'b1;
    fire      = bus_valid & bus_ready;
    wr_here   = fire & bus_sel;
    wr_other  = fire & ~bus_sel;
    wk.evt     = wake_evt;
    wk.clk_sel = wake_clk_sel;
    wk.nodiv   = wake_nodiv;
  end

  fsusp_wake_clr #(.SEL_W(CSEL_W)) u_wake (
    .wake_evt     (wk.evt),
    .wake_clk_sel (wk.clk_sel),
    .wake_nodiv   (wk.nodiv),
    .clr          (lcr_clr)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (GMASK[i]) begin : g_guard
      logic fclr;
      assign fclr = (i == LCR_BIT) ? lcr_clr : 1'b0;
      fsusp_unlock_bit u_ub (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_here   (wr_here),
        .wr_other  (wr_other),
        .wbit      (bus_wdata[i]),
        .force_clr (fclr),
        .q         (reg_q[i])
      );
    end else if (i == REQ_BIT) begin : g_req
      fsusp_req_bit u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_here    (wr_here),
        .wbit       (bus_wdata[i]),
        .rewrite_en (rewrite_en),
        .irq_req    (irq_req),
        .irq_en     (reg_q[IRQEN_BIT]),
        .q          (reg_q[i])
      );
    end else if (PMASK[i]) begin : g_plain
      logic pq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pq <= 1'b0;
        else if (wr_here)
          pq <= bus_wdata[i];
      end
      assign reg_q[i] = pq;
    end else begin : g_none
      assign reg_q[i] = 1'b0;
    end
  end

  always_comb begin
    rd_data         = reg_q;
    suspend_o       = reg_q[EN_BIT] & reg_q[REQ_BIT];
    no_wait_cycle_o = reg_q[WAIT_BIT];
    low_cur_read_o  = reg_q[LCR_BIT];
  end
endmodule

// File: rtl/fsusp_ctl_reg_chk.sv
module fsusp_ctl_reg_chk
  import fsusp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_sel,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  rd_data,
  input logic              irq_req,
  input logic              rewrite_en,
  input logic              wake_evt,
  input logic [CSEL_W-1:0] wake_clk_sel,
  input logic              wake_nodiv,
  input logic              suspend_o
);
  logic wr_here;
  logic clr_cond;
  assign wr_here  = bus_valid & bus_sel;
  assign clr_cond = wake_evt & (wake_clk_sel[1] | wake_nodiv);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && rd_data[IRQEN_BIT]) |=> rd_data[REQ_BIT]);

  // R6
  restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_here && !bus_wdata[REQ_BIT] && !rewrite_en && rd_data[REQ_BIT]) |=> rd_data[REQ_BIT]);

  // R6
  restart_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_here && !bus_wdata[REQ_BIT] && rewrite_en && !(irq_req && rd_data[IRQEN_BIT]))
      |=> !rd_data[REQ_BIT]);

  // R3
  unlock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[EN_BIT]) |-> $past(wr_here && bus_wdata[EN_BIT]));

  // R9
  wake_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cond |=> !rd_data[LCR_BIT]);

  // R9
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_cond && !wr_here) |=> $stable(rd_data[LCR_BIT]));

  // R10
  susp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_o) |-> (rd_data[EN_BIT] && rd_data[REQ_BIT]));
endmodule

bind fsusp_ctl_reg fsusp_ctl_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_sel      (bus_sel),
  .bus_wdata    (bus_wdata),
  .rd_data      (rd_data),
  .irq_req      (irq_req),
  .rewrite_en   (rewrite_en),
  .wake_evt     (wake_evt),
  .wake_clk_sel (wake_clk_sel),
  .wake_nodiv   (wake_nodiv),
  .suspend_o    (suspend_o)
);

// File: tb/fsusp_ctl_reg_test.sv
module fsusp_ctl_reg_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       irq_req = 1'b0;
  logic       rewrite_en = 1'b0;
  logic       wake_evt = 1'b0;
  logic [1:0] wake_clk_sel = 2'b00;
  logic       wake_nodiv = 1'b0;
  logic       bus_ready;
  logic [7:0] rd_data;
  logic       suspend_o;
  logic       no_wait_cycle_o;
  logic       low_cur_read_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fsusp_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .irq_req(irq_req), .rewrite_en(rewrite_en), .wake_evt(wake_evt),
    .wake_clk_sel(wake_clk_sel), .wake_nodiv(wake_nodiv),
    .suspend_o(suspend_o), .no_wait_cycle_o(no_wait_cycle_o),
    .low_cur_read_o(low_cur_read_o)
  );

  // behavioural reference model
  logic [7:0] m_reg = 8'h00;
  int         m_arm[int];
  int         gidx[3] = '{0, 2, 7};

  always @(posedge clk) begin
    logic [7:0] nxt;
    if (!rst_n) begin
      m_reg = 8'h00;
      for (int g = 0; g < 3; g++) m_arm[gidx[g]] = 0;
    end else begin
      nxt = m_reg;
      if (bus_valid && bus_sel) begin
        for (int g = 0; g < 3; g++) begin
          int b;
          b = gidx[g];
          if (bus_wdata[b]) begin
            if (m_arm[b] != 0) nxt[b] = 1'b1;
          end else nxt[b] = 1'b0;
          m_arm[b] = bus_wdata[b] ? 0 : 1;
        end
        nxt[3] = bus_wdata[3];
        nxt[4] = bus_wdata[4];
        nxt[5] = bus_wdata[5];
        if (bus_wdata[1]) nxt[1] = 1'b1;
        else if (rewrite_en) nxt[1] = 1'b0;
      end else if (bus_valid) begin
        for (int g = 0; g < 3; g++) m_arm[gidx[g]] = 0;
      end
      if (irq_req && m_reg[2]) nxt[1] = 1'b1;
      if (wake_evt && (wake_clk_sel[1] || wake_nodiv)) nxt[7] = 1'b0;
      m_reg = nxt;
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (!done) begin
      checks++;
      if (rd_data !== m_reg || suspend_o !== (m_reg[0] & m_reg[1]) ||
          no_wait_cycle_o !== m_reg[4] || low_cur_read_o !== m_reg[7]) begin
        errors++;
        $display("FAIL model R2/R10: rd=%h susp=%b expected rd=%h susp=%b",
                 rd_data, suspend_o, m_reg, m_reg[0] & m_reg[1]);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] exp_rd, input logic exp_s);
    checks++;
    if (rd_data !== exp_rd || suspend_o !== exp_s) begin
      errors++;
      $display("FAIL %s: rd=%h susp=%b expected rd=%h susp=%b",
               req, rd_data, suspend_o, exp_rd, exp_s);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] d,
                      input logic irq, input logic wk, input logic [1:0] cs,
                      input logic nd);
    @(negedge clk);
    bus_valid = v; bus_sel = s; bus_wdata = d; irq_req = irq;
    wake_evt = wk; wake_clk_sel = cs; wake_nodiv = nd;
    @(negedge clk);
    bus_valid = 1'b0; bus_sel = 1'b0; bus_wdata = 8'h00; irq_req = 1'b0;
    wake_evt = 1'b0; wake_clk_sel = 2'b00; wake_nodiv = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, 1'b1, d, 1'b0, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic wake(input logic [1:0] cs, input logic nd);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, cs, nd);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 8'h00, 1'b0);
    checks++;
    if (bus_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 ready: actual=%b expected=1", bus_ready);
    end

    wr(8'h85);
    chk("R3 lone write of 1", 8'h00, 1'b0);
    wr(8'h00); wr(8'h85);
    chk("R3 unlock pair", 8'h85, 1'b0);

    wr(8'h78);
    chk("R2 plain and bit6", 8'h38, 1'b0);
    checks++;
    if (no_wait_cycle_o !== 1'b1) begin
      errors++;
      $display("FAIL R2 wait out: actual=%b expected=1", no_wait_cycle_o);
    end

    wr(8'h00);
    step(1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R4 other address no change", 8'h00, 1'b0);
    wr(8'h85);
    chk("R4 broken unlock", 8'h00, 1'b0);

    step(1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R11 invalid ignored", 8'h00, 1'b0);

    wr(8'h00); wr(8'h01);
    chk("R3 bit0 unlock", 8'h01, 1'b0);
    wr(8'h03);
    chk("R5 sw set and R10 suspend", 8'h03, 1'b1);

    wr(8'h01);
    chk("R6 restart blocked", 8'h03, 1'b1);
    rewrite_en = 1'b1;
    wr(8'h01);
    chk("R6 restart allowed", 8'h01, 1'b0);

    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'b00, 1'b0);
    chk("R7 irq ignored when disabled", 8'h01, 1'b0);
    wr(8'h05);
    chk("R3 bit2 unlock", 8'h05, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 2'b00, 1'b0);
    chk("R7 irq sets request", 8'h07, 1'b1);

    step(1'b1, 1'b1, 8'h05, 1'b1, 1'b0, 2'b00, 1'b0);
    chk("R8 irq beats clear", 8'h07, 1'b1);
    wr(8'h05);
    chk("R6 clear after collision", 8'h05, 1'b0);

    wr(8'h05); wr(8'h85);
    chk("R3 bit7 unlock", 8'h85, 1'b0);
    wake(2'b00, 1'b0);
    chk("R9 wake sel00 holds", 8'h85, 1'b0);
    wake(2'b01, 1'b0);
    chk("R9 wake sel01 holds", 8'h85, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 2'b11, 1'b1);
    chk("R9 no wake event holds", 8'h85, 1'b0);
    wake(2'b10, 1'b0);
    chk("R9 wake sel10 clears", 8'h05, 1'b0);
    wr(8'h05); wr(8'h85);
    wake(2'b11, 1'b0);
    chk("R9 wake sel11 clears", 8'h05, 1'b0);
    wr(8'h05); wr(8'h85);
    wake(2'b00, 1'b1);
    chk("R9 wake nodiv clears", 8'h05, 1'b0);
    wr(8'h05);
    step(1'b1, 1'b1, 8'h85, 1'b0, 1'b1, 2'b10, 1'b0);
    chk("R9 wake beats write", 8'h05, 1'b0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule